// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. Its inputs are the four status flags that a preceding compare leaves behind (carry, zero, sign, overflow) and a 4-bit condition code. It drives a single taken bit.

The supported tests are:

- equality and inequality;
- four unsigned orderings, which use carry and zero;
- four signed orderings, which use the agreement of sign and overflow together with zero;
- an always-taken code and a never-taken code.

For the signed tests, the true sign of the difference is taken as sign XOR overflow. The sign flag alone is not used, because an overflowed subtraction leaves it inverted.

Two views of the decision are provided. The combinational result is available in the same cycle as the inputs. A registered copy is captured whenever the valid strobe is high, and a one-cycle valid pulse goes with each capture.

Top module: `branch_cond_unit`

## Requirements
- R1: Code 0 (equal) gives taken = Z, and code 1 (not equal) gives taken = NOT Z, on the combinational output in the same cycle.
- R2: Code 2 (unsigned below) gives taken = C, and code 5 (unsigned above-or-equal) gives taken = NOT C.
- R3: Code 3 (unsigned below-or-equal) gives taken = C OR Z, and code 4 (unsigned above) gives taken = NOT C AND NOT Z.
- R4: Code 6 (signed less) gives taken = S XOR O, and code 9 (signed greater-or-equal) gives taken = S XNOR O.
- R5: Code 7 (signed less-or-equal) gives taken = (S XOR O) OR Z, and code 8 (signed greater) gives taken = (S XNOR O) AND NOT Z.
- R6: Code 10 always gives taken = 1, and code 11 always gives taken = 0, whatever the flags are.
- R7: Codes 12 to 15 give taken = 0 for every flag combination.
- R8: When the valid strobe is high at a rising clock edge, the registered output takes the combinational decision of that cycle, and the registered-valid output is 1 for the following cycle only.
- R9: When the valid strobe is low at a rising edge, the registered output keeps its value and the registered-valid output is 0.
- R10: While the synchronous active-low reset is low at a clock edge, the registered output and the registered-valid output both become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_c | input | 1 | Carry/borrow flag from the compare |
| flag_z | input | 1 | Zero flag from the compare |
| flag_s | input | 1 | Sign flag from the compare |
| flag_o | input | 1 | Overflow flag from the compare |
| cond | input | CODE_W | Condition code (encoding as in R1 to R7) |
| sample_vld | input | 1 | Strobe that captures the decision into the register |
| taken_comb | output | 1 | Combinational branch decision |
| taken_q | output | 1 | Registered branch decision |
| taken_q_vld | output | 1 | One-cycle pulse marking a fresh registered decision |

## Verification
The assertions check the flag equation of every condition code against the combinational output on every cycle, and they check that undefined codes never yield taken. They also check that the register captures on a strobe and holds without one.

Only the bench scenarios show certain behaviours. The first is the exhaustive sweep of all 256 code and flag pairs against an independent model. The others are the register holding over long idle stretches after a taken and after a not-taken capture, and the output state during reset.

// File: rtl/brc_pkg.sv
// Package: shared types for the branch condition evaluator.
// Assumes: condition codes at or above CC_FIRST_UNDEF are reserved.
package brc_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        CC_EQ     = 4'd0,
        CC_NE     = 4'd1,
        CC_ULT    = 4'd2,
        CC_ULE    = 4'd3,
        CC_UGT    = 4'd4,
        CC_UGE    = 4'd5,
        CC_SLT    = 4'd6,
        CC_SLE    = 4'd7,
        CC_SGT    = 4'd8,
        CC_SGE    = 4'd9,
        CC_ALWAYS = 4'd10,
        CC_NEVER  = 4'd11
    } cc_e;

    localparam int CC_FIRST_UNDEF = 12;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
    } flags_t;

    typedef struct packed {
        logic eq;   // operands equal
        logic ltu;  // unsigned strictly less
        logic leu;  // unsigned less or equal
        logic lts;  // signed strictly less
        logic les;  // signed less or equal
    } rel_t;
endpackage

// File: rtl/brc_relations.sv
// Module: brc_relations
// Derives the base ordering relations from the compare flags.
// Assumes: the flags come from dest - src. The true sign of the
// difference is s ^ o, because overflow inverts the sign flag.
module brc_relations
    import brc_pkg::*;
(
    input  flags_t flg,
    output rel_t   rel
);
    logic true_neg;

    // Corrected sign of the difference, and the relations built from it.
    always_comb begin
        true_neg = flg.s ^ flg.o;
        rel.eq   = flg.z;
        rel.ltu  = flg.c;
        rel.leu  = flg.c | flg.z;
        rel.lts  = true_neg;
        rel.les  = true_neg | flg.z;
    end
endmodule

// File: rtl/brc_select.sv
// Module: brc_select
// Picks one relation, or its complement, according to the condition code.
// Assumes: reserved codes must never branch, so they give 0.
module brc_select
    import brc_pkg::*;
#(
    parameter int CODE_W_P = CODE_W
) (
    input  rel_t                rel,
    input  logic [CODE_W_P-1:0] cc,
    output logic                taken
);
    // Decode the condition code onto the relation vector.
    always_comb begin
        case (cc)
            CC_EQ:     taken = rel.eq;
            CC_NE:     taken = ~rel.eq;
            CC_ULT:    taken = rel.ltu;
            CC_ULE:    taken = rel.leu;
            CC_UGT:    taken = ~rel.leu;
            CC_UGE:    taken = ~rel.ltu;
            CC_SLT:    taken = rel.lts;
            CC_SLE:    taken = rel.les;
            CC_SGT:    taken = ~rel.les;
            CC_SGE:    taken = ~rel.lts;
            CC_ALWAYS: taken = 1'b1;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/brc_sample_reg.sv
// Module: brc_sample_reg
// Captures the decision on a valid strobe and emits a one-cycle valid pulse.
// Assumes: synchronous active-low reset; the value holds while no strobe arrives.
module brc_sample_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic load,
    output logic q,
    output logic q_vld
);
    // Register the decision when strobed, and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= 1'b0;
            q_vld <= 1'b0;
        end else begin
            if (load) q <= d;
            q_vld <= load;
        end
    end
endmodule

// File: rtl/branch_cond_unit.sv
// Module: branch_cond_unit
// Top level of the branch condition evaluator: the combinational decision
// plus a registered copy that is sampled on sample_vld.
// Assumes: the flags are stable in the cycle the decision is needed.
module branch_cond_unit
    import brc_pkg::*;
#(
    parameter int CODE_W_P = CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flag_c,
    input  logic                flag_z,
    input  logic                flag_s,
    input  logic                flag_o,
    input  logic [CODE_W_P-1:0] cond,
    input  logic                sample_vld,
    output logic                taken_comb,
    output logic                taken_q,
    output logic                taken_q_vld
);
    flags_t flg;
    rel_t   rel;

    // Bundle the flag pins into the shared struct.
    always_comb flg = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o};

    brc_relations u_rel (
        .flg (flg),
        .rel (rel)
    );

    brc_select #(.CODE_W_P(CODE_W_P)) u_sel (
        .rel   (rel),
        .cc    (cond),
        .taken (taken_comb)
    );

    brc_sample_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (taken_comb),
        .load  (sample_vld),
        .q     (taken_q),
        .q_vld (taken_q_vld)
    );

    // R1
    eq_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CC_EQ || cond == CC_NE) |-> (taken_comb == (flag_z ^ (cond == CC_NE))));
    // R2
    ult_uge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CC_ULT || cond == CC_UGE) |-> (taken_comb == (flag_c ^ (cond == CC_UGE))));
    // R3
    ule_ugt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CC_ULE || cond == CC_UGT) |-> (taken_comb == ((flag_c | flag_z) ^ (cond == CC_UGT))));
    // R4
    slt_sge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CC_SLT || cond == CC_SGE) |-> (taken_comb == ((flag_s != flag_o) ^ (cond == CC_SGE))));
    // R5
    sle_sgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CC_SLE || cond == CC_SGT) |-> (taken_comb == (((flag_s != flag_o) | flag_z) ^ (cond == CC_SGT))));
    // R6
    const_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CC_ALWAYS || cond == CC_NEVER) |-> (taken_comb == (cond == CC_ALWAYS)));
    // R7
    undef_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cond) >= CC_FIRST_UNDEF) |-> !taken_comb);
    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> (taken_q == $past(taken_comb)) && taken_q_vld);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(taken_q) && !taken_q_vld);
endmodule

// File: tb/branch_cond_unit_tb.sv
module branch_cond_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       flag_c, flag_z, flag_s, flag_o;
    logic [3:0] cond;
    logic       sample_vld;
    logic       taken_comb, taken_q, taken_q_vld;

    int checks = 0;
    int errors = 0;
    bit run_chk = 1'b0;
    bit exp_q = 1'b0;
    bit exp_v = 1'b0;

    always #5 clk = ~clk;

    branch_cond_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
        .cond(cond), .sample_vld(sample_vld),
        .taken_comb(taken_comb), .taken_q(taken_q), .taken_q_vld(taken_q_vld)
    );

    // Reference model: decide from the signed and unsigned meaning of the flags.
    function automatic bit ref_taken(int code, bit c, bit z, bit s, bit o);
        bit below = c;         // unsigned dest < src
        bit less  = (s != o);  // signed dest < src
        case (code)
            0:  return z;
            1:  return !z;
            2:  return below;
            3:  return below || z;
            4:  return !below && !z;
            5:  return !below;
            6:  return less;
            7:  return less || z;
            8:  return !less && !z;
            9:  return !less;
            10: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(int code);
        case (code)
            0, 1:    return "R1";
            2, 5:    return "R2";
            3, 4:    return "R3";
            6, 9:    return "R4";
            7, 8:    return "R5";
            10, 11:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (cond=%0d flags c%0b z%0b s%0b o%0b)",
                     req, what, act, exp, cond, flag_c, flag_z, flag_s, flag_o);
        end
    endtask

    // Cycle model of the registered view.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q = 1'b0;
            exp_v = 1'b0;
        end else begin
            if (sample_vld) exp_q = ref_taken(int'(cond), flag_c, flag_z, flag_s, flag_o);
            exp_v = sample_vld;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (run_chk) begin
            check(req_of(int'(cond)), "taken_comb", taken_comb,
                  ref_taken(int'(cond), flag_c, flag_z, flag_s, flag_o));
            if (!rst_n) begin
                check("R10", "taken_q", taken_q, exp_q);
                check("R10", "taken_q_vld", taken_q_vld, exp_v);
            end else begin
                check(exp_v ? "R8" : "R9", "taken_q", taken_q, exp_q);
                check(exp_v ? "R8" : "R9", "taken_q_vld", taken_q_vld, exp_v);
            end
        end
    end

    task automatic drive(int code, int fl, bit vld);
        @(posedge clk);
        #1;
        cond       = code[3:0];
        flag_c     = fl[3];
        flag_z     = fl[2];
        flag_s     = fl[1];
        flag_o     = fl[0];
        sample_vld = vld;
    endtask

    initial begin
        rst_n = 1'b0; cond = 4'd10; sample_vld = 1'b1;
        flag_c = 1'b0; flag_z = 1'b0; flag_s = 1'b0; flag_o = 1'b0;
        @(posedge clk);
        run_chk = 1'b1;
        repeat (3) @(posedge clk);   // R10: reset overrides the strobe
        #1 rst_n = 1'b1;
        // Exhaustive sweep of every code and flag set, strobing every third step.
        for (int code = 0; code < 16; code++)
            for (int fl = 0; fl < 16; fl++)
                drive(code, fl, ((code * 16 + fl) % 3) == 0);
        // R9: capture a taken, then hold it while flags and code churn.
        drive(10, 0, 1'b1);
        for (int k = 0; k < 12; k++) drive(k % 16, (k * 5) % 16, 1'b0);
        // R9: capture a not-taken, then hold it.
        drive(11, 15, 1'b1);
        for (int k = 0; k < 12; k++) drive(10, k, 1'b0);
        // R8: back-to-back strobes that alternate the decision.
        for (int k = 0; k < 8; k++) drive(0, (k % 2) * 4, 1'b1);
        // R10: a reset in mid-run clears the register.
        drive(10, 0, 1'b1);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(1, 0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        run_chk = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule